// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block watches the reference and feedback pulses that feed a phase-locked loop's phase comparator. It decides, from the timing of their rising edges, whether the loop is locked. Both pulses are resynchronised into a fast sample clock. The phase error of each comparison cycle is measured as the number of sample-clock cycles between the two rising edges, whichever edge comes first.

The detector uses hysteresis. While it is unlocked, a comparison cycle counts as good only when its error is inside a narrow window. Lock is declared after a fixed run of good cycles in a row. Once locked, the detector drops lock only when an error exceeds a wider window. An edge that finds no partner before a timeout counts as an error outside both windows.

Three controls adjust the behaviour. A divide-by-4 option evaluates only every fourth measurement, for fast comparison rates. A polarity select chooses whether lock is shown as a high or a low level. Power-down forces the no-lock level and clears the lock state.

Top module: `pll_lock_detect`

## Requirements
- R1: The phase error is the number of sample-clock cycles between the rising edges of the reference and feedback inputs, measured the same way whichever edge comes first. Edges that arrive in the same cycle give an error of 0.
- R2: While unlocked, a measurement is good only if its error is strictly below TIGHT_WIN (default 2 cycles). An error equal to TIGHT_WIN is not good.
- R3: The internal lock state is set when LOCK_RUN (default 5) evaluated measurements in a row are good. After only LOCK_RUN-1 good measurements the block stays unlocked.
- R4: While unlocked, an evaluated measurement that is not good clears the count of consecutive good measurements to zero.
- R5: While locked, a measurement with error up to and including WIDE_WIN (default 4) keeps lock. An error greater than WIDE_WIN clears the lock state and the good count.
- R6: If one rising edge is not followed by a partner edge within TIMEOUT (default 16) cycles, the measurement is treated as outside both windows. A second edge on the same input before the partner edge is treated the same way.
- R7: With div4_en_i high, only measurements 0, 4, 8 and so on are evaluated, counting from reset or power-down. The other measurements do not affect the lock state.
- R8: With lock_pol_low_i at 0, lock_o is 1 when locked and 0 when not. With lock_pol_low_i at 1, the levels are inverted.
- R9: While pwrdn_i is high, lock_o shows the no-lock level for the selected polarity (0 for active-high, 1 for active-low). The lock state, the good count and the measurement are cleared, so lock must be acquired again afterwards.
- R10: After reset the block is unlocked with its good count cleared, and lock_o is at the no-lock level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ref_i | input | 1 | Reference pulse at the comparator input (asynchronous) |
| fb_i | input | 1 | Feedback pulse at the comparator input (asynchronous) |
| pwrdn_i | input | 1 | Power-down: forces no-lock and clears the lock state |
| lock_pol_low_i | input | 1 | 1 selects an active-low lock output |
| div4_en_i | input | 1 | 1 evaluates only every fourth measurement |
| lock_o | output | 1 | Lock indication level |

## Verification
The bench drives errors exactly at the edges of each window: an error equal to TIGHT_WIN while unlocked, and errors equal to and one above WIDE_WIN while locked. A design with an off-by-one compare would lock too early or drop lock too late. It interrupts a run of good cycles with one bad one, which catches a counter that only saturates or never clears. It also sends lone edges to check that a missing partner cannot leave the measurement hung or be taken as a small error. The divide-by-4 test places one bad measurement on a skipped slot and one on an evaluated slot, so an off-by-one prescaler phase shows up. Power-down is checked in both polarities, and afterwards the bench confirms that lock has to be acquired again.

// File: rtl/pll_lock_detect_pkg.sv
package pll_lock_detect_pkg;
  typedef enum logic [1:0] {
    MS_IDLE     = 2'd0,
    MS_WAIT_FB  = 2'd1,
    MS_WAIT_REF = 2'd2
  } meter_state_e;
endpackage

// File: rtl/pld_rst_sync.sv
module pld_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/pld_edge_sync.sv
module pld_edge_sync #(
  parameter int CHANNELS = 2,
  parameter int STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CHANNELS-1:0] async_i,
  output logic [CHANNELS-1:0] rise_o
);
  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-1:0], async_i[c]};
    end

    assign rise_o[c] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  end
endmodule

// File: rtl/pld_phase_meter.sv
module pld_phase_meter
  import pll_lock_detect_pkg::*;
#(
  parameter int TIMEOUT = 16,
  parameter int CW      = $clog2(TIMEOUT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          ref_rise_i,
  input  logic          fb_rise_i,
  output logic          meas_vld_o,
  output logic [CW-1:0] meas_err_o,
  output logic          meas_miss_o
);
  localparam logic [CW-1:0] CNT_MAX = CW'(TIMEOUT);

  meter_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          vld_q, vld_d;
  logic [CW-1:0] err_q, err_d;
  logic          miss_q, miss_d;
  logic          partner, same;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    vld_d   = 1'b0;
    err_d   = err_q;
    miss_d  = 1'b0;
    partner = (st_q == MS_WAIT_FB) ? fb_rise_i : ref_rise_i;
    same    = (st_q == MS_WAIT_FB) ? ref_rise_i : fb_rise_i;
    if (clr_i) begin
      st_d  = MS_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        MS_IDLE: begin
          if (ref_rise_i && fb_rise_i) begin
            vld_d = 1'b1;
            err_d = '0;
          end else if (ref_rise_i) begin
            st_d  = MS_WAIT_FB;
            cnt_d = CW'(1);
          end else if (fb_rise_i) begin
            st_d  = MS_WAIT_REF;
            cnt_d = CW'(1);
          end
        end
        MS_WAIT_FB, MS_WAIT_REF: begin
          if (partner) begin
            vld_d = 1'b1;
            err_d = cnt_q;
            st_d  = MS_IDLE;
            cnt_d = '0;
          end else if (same) begin
            vld_d  = 1'b1;
            miss_d = 1'b1;
            cnt_d  = CW'(1);
          end else if (cnt_q == CNT_MAX) begin
            vld_d  = 1'b1;
            miss_d = 1'b1;
            st_d   = MS_IDLE;
            cnt_d  = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        default: begin
          st_d  = MS_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= MS_IDLE;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      err_q  <= '0;
      miss_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
      err_q  <= err_d;
      miss_q <= miss_d;
    end
  end

  assign meas_vld_o  = vld_q;
  assign meas_err_o  = err_q;
  assign meas_miss_o = miss_q;
endmodule

// File: rtl/pld_lock_eval.sv
module pld_lock_eval #(
  parameter int TIGHT_WIN = 2,
  parameter int WIDE_WIN  = 4,
  parameter int LOCK_RUN  = 5,
  parameter int CW        = 5,
  parameter int RW        = $clog2(LOCK_RUN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          div4_en_i,
  input  logic          meas_vld_i,
  input  logic [CW-1:0] meas_err_i,
  input  logic          meas_miss_i,
  output logic          locked_o,
  output logic          eval_o,
  output logic          good_o,
  output logic          bad_o,
  output logic [RW-1:0] run_o
);
  localparam logic [CW-1:0] TIGHT_C = CW'(TIGHT_WIN);
  localparam logic [CW-1:0] WIDE_C  = CW'(WIDE_WIN);
  localparam logic [RW-1:0] RUN_LAST = RW'(LOCK_RUN - 1);

  logic [1:0]    pre_q, pre_d;
  logic [RW-1:0] run_q, run_d;
  logic          lock_q, lock_d;
  logic          eval, good, bad;

  assign eval = meas_vld_i && (!div4_en_i || pre_q == 2'd0);
  assign good = !meas_miss_i && (meas_err_i < TIGHT_C);
  assign bad  = meas_miss_i || (meas_err_i > WIDE_C);

  always_comb begin
    pre_d  = pre_q;
    run_d  = run_q;
    lock_d = lock_q;
    if (clr_i) begin
      pre_d  = 2'd0;
      run_d  = '0;
      lock_d = 1'b0;
    end else begin
      if (!div4_en_i)      pre_d = 2'd0;
      else if (meas_vld_i) pre_d = pre_q + 2'd1;
      if (eval) begin
        if (!lock_q) begin
          if (!good) begin
            run_d = '0;
          end else if (run_q == RUN_LAST) begin
            run_d  = '0;
            lock_d = 1'b1;
          end else begin
            run_d = run_q + RW'(1);
          end
        end else if (bad) begin
          lock_d = 1'b0;
          run_d  = '0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= 2'd0;
      run_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      run_q  <= run_d;
      lock_q <= lock_d;
    end
  end

  assign locked_o = lock_q;
  assign eval_o   = eval;
  assign good_o   = good;
  assign bad_o    = bad;
  assign run_o    = run_q;
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
  parameter int TIGHT_WIN   = 2,
  parameter int WIDE_WIN    = 4,
  parameter int LOCK_RUN    = 5,
  parameter int TIMEOUT     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic fb_i,
  input  logic pwrdn_i,
  input  logic lock_pol_low_i,
  input  logic div4_en_i,
  output logic lock_o
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam int RW = $clog2(LOCK_RUN + 1);

  logic          rst_sync_n;
  logic [1:0]    rise;
  logic          meas_vld, meas_miss;
  logic [CW-1:0] meas_err;
  logic          locked, eval, good, bad;
  logic [RW-1:0] run;

  pld_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  pld_edge_sync #(.CHANNELS(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .async_i ({fb_i, ref_i}),
    .rise_o  (rise)
  );

  pld_phase_meter #(.TIMEOUT(TIMEOUT), .CW(CW)) u_meter (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .clr_i       (pwrdn_i),
    .ref_rise_i  (rise[0]),
    .fb_rise_i   (rise[1]),
    .meas_vld_o  (meas_vld),
    .meas_err_o  (meas_err),
    .meas_miss_o (meas_miss)
  );

  pld_lock_eval #(
    .TIGHT_WIN (TIGHT_WIN),
    .WIDE_WIN  (WIDE_WIN),
    .LOCK_RUN  (LOCK_RUN),
    .CW        (CW),
    .RW        (RW)
  ) u_eval (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .clr_i       (pwrdn_i),
    .div4_en_i   (div4_en_i),
    .meas_vld_i  (meas_vld),
    .meas_err_i  (meas_err),
    .meas_miss_i (meas_miss),
    .locked_o    (locked),
    .eval_o      (eval),
    .good_o      (good),
    .bad_o       (bad),
    .run_o       (run)
  );

  assign lock_o = (locked & ~pwrdn_i) ^ lock_pol_low_i;
endmodule

// File: rtl/pll_lock_detect_chk.sv
module pll_lock_detect_chk #(
  parameter int LOCK_RUN = 5,
  parameter int RW       = 3
) (
  input logic          clk_i,
  input logic          rst_sync_n,
  input logic          pwrdn_i,
  input logic          lock_pol_low_i,
  input logic          lock_o,
  input logic          locked,
  input logic          eval,
  input logic          good,
  input logic          bad,
  input logic [RW-1:0] run
);
  // R9
  pwrdn_level_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    pwrdn_i |-> (lock_o == lock_pol_low_i));

  // R3
  lock_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(locked) |-> $past(eval && good && !pwrdn_i));

  // R5
  lock_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $fell(locked) |-> $past((eval && bad) || pwrdn_i));

  // R4
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    run < RW'(LOCK_RUN));

  // R5
  run_idle_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    locked |-> (run == '0));
endmodule

bind pll_lock_detect pll_lock_detect_chk #(.LOCK_RUN(LOCK_RUN), .RW(RW)) u_chk (
  .clk_i          (clk_i),
  .rst_sync_n     (rst_sync_n),
  .pwrdn_i        (pwrdn_i),
  .lock_pol_low_i (lock_pol_low_i),
  .lock_o         (lock_o),
  .locked         (locked),
  .eval           (eval),
  .good           (good),
  .bad            (bad),
  .run            (run)
);

// File: tb/sim_pll_lock_detect.sv
`timescale 1ns/1ps
module sim_pll_lock_detect;
  logic clk = 1'b0;
  logic rst_n, ref_p, fb_p, pwrdn, pol_low, div4;
  logic lock;
  int   total = 0;
  int   bad   = 0;

  always #2.5 clk = ~clk;

  pll_lock_detect u0 (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .ref_i          (ref_p),
    .fb_i           (fb_p),
    .pwrdn_i        (pwrdn),
    .lock_pol_low_i (pol_low),
    .div4_en_i      (div4),
    .lock_o         (lock)
  );

  task automatic check(input logic exp, input string req);
    total++;
    if (lock !== exp) begin
      bad++;
      $display("FAIL %s: lock_o=%b expected %b", req, lock, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ref_p = 1'b0; fb_p = 1'b0;
    pwrdn = 1'b0; pol_low = 1'b0; div4 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // One comparison period of 24 clocks. The leading edge rises at t=0;
  // the trailing one rises at t=d unless lone is set.
  task automatic comp(input int d, input bit fb_first, input bit lone);
    for (int t = 0; t < 24; t++) begin
      logic a, b;
      @(negedge clk);
      a = (t < 3);
      b = !lone && (t >= d) && (t < d + 3);
      ref_p = fb_first ? b : a;
      fb_p  = fb_first ? a : b;
    end
  endtask

  task automatic acquire();
    for (int i = 0; i < 5; i++) comp(1, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    check(1'b0, "R10 reset level");
  endtask

  task automatic t_acquire();
    do_reset();
    for (int i = 0; i < 4; i++) begin
      comp(1, 1'b0, 1'b0);
      check(1'b0, "R3 before run complete");
    end
    comp(1, 1'b0, 1'b0);
    check(1'b1, "R3 lock after run");
  endtask

  task automatic t_order();
    do_reset();
    for (int i = 0; i < 5; i++) comp(1, 1'b1, 1'b0);
    check(1'b1, "R1 feedback-first error 1");
    do_reset();
    for (int i = 0; i < 5; i++) comp(0, 1'b0, 1'b0);
    check(1'b1, "R1 coincident edges error 0");
  endtask

  task automatic t_tight();
    do_reset();
    for (int i = 0; i < 5; i++) comp(2, 1'b0, 1'b0);
    check(1'b0, "R2 error equal to tight window");
    do_reset();
    for (int i = 0; i < 4; i++) comp(1, 1'b0, 1'b0);
    comp(2, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) comp(1, 1'b0, 1'b0);
    check(1'b0, "R4 run cleared by bad cycle");
    comp(1, 1'b0, 1'b0);
    check(1'b1, "R4 lock after fresh run");
  endtask

  task automatic t_hyst();
    do_reset();
    acquire();
    comp(3, 1'b0, 1'b0);
    check(1'b1, "R5 error 3 keeps lock");
    comp(4, 1'b1, 1'b0);
    check(1'b1, "R5 error at wide window keeps lock");
    comp(5, 1'b0, 1'b0);
    check(1'b0, "R5 error above wide window drops lock");
    for (int i = 0; i < 4; i++) comp(1, 1'b0, 1'b0);
    check(1'b0, "R5 counter cleared on drop");
  endtask

  task automatic t_timeout();
    do_reset();
    acquire();
    comp(0, 1'b1, 1'b1);
    check(1'b0, "R6 lone edge drops lock");
    acquire();
    check(1'b1, "R6 meter recovers after timeout");
  endtask

  task automatic t_div4();
    do_reset();
    div4 = 1'b1;
    for (int i = 0; i < 16; i++) comp(1, 1'b0, 1'b0);
    check(1'b0, "R7 sixteen measurements not enough");
    comp(1, 1'b0, 1'b0);
    check(1'b1, "R7 lock at measurement 16");
    comp(0, 1'b0, 1'b1);
    check(1'b1, "R7 skipped slot ignored");
    comp(1, 1'b0, 1'b0);
    comp(1, 1'b0, 1'b0);
    comp(0, 1'b0, 1'b1);
    check(1'b0, "R7 evaluated slot drops lock");
  endtask

  task automatic t_pol();
    do_reset();
    pol_low = 1'b1;
    @(negedge clk);
    check(1'b1, "R8 active-low unlocked");
    acquire();
    check(1'b0, "R8 active-low locked");
    pol_low = 1'b0;
    @(negedge clk);
    check(1'b1, "R8 active-high locked");
  endtask

  task automatic t_pwrdn();
    do_reset();
    acquire();
    pwrdn = 1'b1;
    @(negedge clk);
    check(1'b0, "R9 power-down active-high");
    pol_low = 1'b1;
    @(negedge clk);
    check(1'b1, "R9 power-down active-low");
    repeat (4) @(negedge clk);
    pwrdn = 1'b0;
    pol_low = 1'b0;
    @(negedge clk);
    check(1'b0, "R9 lock state cleared");
    comp(1, 1'b0, 1'b0);
    check(1'b0, "R9 must reacquire");
    for (int i = 0; i < 4; i++) comp(1, 1'b0, 1'b0);
    check(1'b1, "R9 reacquired");
  endtask

  initial begin
    rst_n = 1'b0; ref_p = 1'b0; fb_p = 1'b0;
    pwrdn = 1'b0; pol_low = 1'b0; div4 = 1'b0;
    t_reset();
    t_acquire();
    t_order();
    t_tight();
    t_hyst();
    t_timeout();
    t_div4();
    t_pol();
    t_pwrdn();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule